// File: doc/BRIEF.md
# Early Branch Resolution Fetch Unit

This block holds the program counter and the fetch/decode pipeline register of a five-stage in-order pipeline. The five stages are fetch, decode/register read, execute, memory and write-back. Conditional branches are resolved while the branch is in decode. The zero test on the already-forwarded register operand is made there, and the target adder also sits there. As a result, a taken branch redirects fetch after only one cycle rather than the three cycles needed when resolution waits for a later stage.

Each cycle the decoder reports the branch kind of the instruction it holds, the forwarded register value and the branch offset. The unit then chooses the next fetch address. Two modes set what happens to the instruction fetched just behind a taken branch. In delayed mode that instruction is the single delay slot and always proceeds. In predict-not-taken mode fetch runs ahead sequentially, and the fall-through instruction is squashed into a bubble when the branch is taken.

An external stall freezes the whole unit. On reset the unit fetches from a fixed vector.

Top module: `early_branch_fetch`

## Requirements
- R1: While `rst` is high, and in the first cycle after it falls, `fetch_pc` equals parameter `RESET_VEC` and `fd_valid` is 0.
- R2: In a cycle that is not stalled and has no taken branch, the next `fetch_pc` is the current `fetch_pc` + 4. The fetch/decode register captures the current `fetch_pc` and `fetch_instr` with `fd_valid` = 1.
- R3: The branch code `dec_br` uses these values: 0 = no branch, 1 = taken when `dec_rs_val` is zero, 2 = taken when `dec_rs_val` is non-zero, 3 = never taken. The code 3 is treated as no branch.
- R4: When a branch is taken and the unit is not stalled, the next `fetch_pc` is `fd_pc` + 4 + (sign-extended `dec_offset` shifted left by 2).
- R5: When `delay_mode` = 0 and a branch is taken without stall, `squash` is 1 in that cycle and `fd_valid` is 0 in the next cycle.
- R6: When `delay_mode` = 0 and the branch is not taken, `squash` stays 0 and fetch continues sequentially.
- R7: When `delay_mode` = 1 and a branch is taken, `squash` stays 0. The instruction in fetch enters decode with `fd_valid` = 1, and the fetch after it comes from the target.
- R8: While `stall` is 1, `fetch_pc`, `fd_valid`, `fd_pc` and `fd_instr` keep their values, `squash` is 0, and any branch decision is ignored.
- R9: A branch code is ignored while `fd_valid` is 0. No redirect and no squash happen, and fetch advances sequentially.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| stall | input | 1 | Freeze PC and fetch/decode register |
| delay_mode | input | 1 | 1 = one delay slot, 0 = predict not taken with squash |
| fetch_instr | input | 32 | Instruction word returned for `fetch_pc` |
| dec_br | input | 2 | Branch code of the instruction in decode |
| dec_rs_val | input | 32 | Forwarded register operand tested against zero |
| dec_offset | input | 16 | Word offset of the branch in decode |
| fetch_pc | output | 32 | Address being fetched |
| squash | output | 1 | Instruction in fetch is on the wrong path |
| fd_valid | output | 1 | Decode slot holds a live instruction |
| fd_pc | output | 32 | PC of the instruction in decode |
| fd_instr | output | 32 | Instruction word in decode |

## Verification
The bench aims at the following cases:
- A branch whose condition depends on an exactly-zero operand, in both senses of the test. A swapped or inverted zero test would redirect on the wrong cases.
- A negative offset. A target adder without sign extension would jump far forward instead of backward.
- A taken branch under stall, and a branch code sitting on a bubble. A unit that ignored either guard would redirect or squash spuriously.
- The same taken branch in each mode. A mixed-up mode would either kill the delay slot or let a wrong-path instruction live.

// File: rtl/fetch_pkg.sv
package fetch_pkg;
    localparam int unsigned XLEN  = 32;
    localparam int unsigned OFF_W = 16;
    localparam int unsigned INSTR_BYTES = 4;

    typedef enum logic [1:0] {
        BR_NONE = 2'd0,
        BR_EQZ  = 2'd1,
        BR_NEZ  = 2'd2,
        BR_RSVD = 2'd3
    } br_kind_e;

    typedef struct packed {
        logic            valid;
        logic [XLEN-1:0] pc;
        logic [XLEN-1:0] instr;
    } fd_slot_t;

    function automatic logic [XLEN-1:0] word_offset(input logic [OFF_W-1:0] off);
        return {{(XLEN-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    endfunction
endpackage

// File: rtl/branch_resolve.sv
module branch_resolve
    import fetch_pkg::*;
(
    input  br_kind_e         kind,
    input  logic             slot_valid,
    input  logic [XLEN-1:0]  rs_val,
    input  logic [XLEN-1:0]  slot_pc,
    input  logic [OFF_W-1:0] offset,
    output logic             taken,
    output logic [XLEN-1:0]  target
);
    logic is_zero;
    logic cond_met;

    assign is_zero = (rs_val == '0);

    always_comb begin
        unique case (kind)
            BR_EQZ:  cond_met = is_zero;
            BR_NEZ:  cond_met = !is_zero;
            default: cond_met = 1'b0;
        endcase
    end

    assign taken  = slot_valid && cond_met;
    assign target = slot_pc + XLEN'(INSTR_BYTES) + word_offset(offset);
endmodule

// File: rtl/fetch_pc_reg.sv
module fetch_pc_reg
    import fetch_pkg::*;
#(
    parameter logic [XLEN-1:0] RESET_VEC = '0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            redirect,
    input  logic [XLEN-1:0] target,
    output logic [XLEN-1:0] pc
);
    logic [XLEN-1:0] seq_pc;
    assign seq_pc = pc + XLEN'(INSTR_BYTES);

    always_ff @(posedge clk) begin
        if (rst)
            pc <= RESET_VEC;
        else if (!hold)
            pc <= redirect ? target : seq_pc;
    end
endmodule

// File: rtl/fd_stage_reg.sv
module fd_stage_reg
    import fetch_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            hold,
    input  logic            kill,
    input  logic [XLEN-1:0] in_pc,
    input  logic [XLEN-1:0] in_instr,
    output fd_slot_t        slot
);
    always_ff @(posedge clk) begin
        if (rst) begin
            slot <= '0;
        end else if (!hold) begin
            slot.valid <= !kill;
            slot.pc    <= in_pc;
            slot.instr <= in_instr;
        end
    end
endmodule

// File: rtl/early_branch_fetch.sv
module early_branch_fetch
    import fetch_pkg::*;
#(
    parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        stall,
    input  logic        delay_mode,
    input  logic [31:0] fetch_instr,
    input  logic [1:0]  dec_br,
    input  logic [31:0] dec_rs_val,
    input  logic [15:0] dec_offset,
    output logic [31:0] fetch_pc,
    output logic        squash,
    output logic        fd_valid,
    output logic [31:0] fd_pc,
    output logic [31:0] fd_instr
);
    fd_slot_t        slot;
    logic            br_taken;
    logic [XLEN-1:0] br_target;
    logic            redirect;

    branch_resolve u_resolve (
        .kind      (br_kind_e'(dec_br)),
        .slot_valid(slot.valid),
        .rs_val    (dec_rs_val),
        .slot_pc   (slot.pc),
        .offset    (dec_offset),
        .taken     (br_taken),
        .target    (br_target)
    );

    assign redirect = br_taken && !stall;
    assign squash   = redirect && !delay_mode;

    fetch_pc_reg #(.RESET_VEC(RESET_VEC)) u_pc (
        .clk     (clk),
        .rst     (rst),
        .hold    (stall),
        .redirect(redirect),
        .target  (br_target),
        .pc      (fetch_pc)
    );

    fd_stage_reg u_fd (
        .clk     (clk),
        .rst     (rst),
        .hold    (stall),
        .kill    (squash),
        .in_pc   (fetch_pc),
        .in_instr(fetch_instr),
        .slot    (slot)
    );

    assign fd_valid = slot.valid;
    assign fd_pc    = slot.pc;
    assign fd_instr = slot.instr;
endmodule

// File: rtl/early_branch_fetch_chk.sv
module early_branch_fetch_chk #(
    parameter logic [31:0] RESET_VEC = 32'h0000_1000
) (
    input logic        clk,
    input logic        rst,
    input logic        stall,
    input logic        delay_mode,
    input logic        br_taken,
    input logic [15:0] dec_offset,
    input logic [31:0] fetch_pc,
    input logic        squash,
    input logic        fd_valid,
    input logic [31:0] fd_pc,
    input logic [31:0] fd_instr
);
    assert_reset_vec_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (fetch_pc == RESET_VEC && !fd_valid));

    assert_seq_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!stall && !br_taken) |=> (fetch_pc == $past(fetch_pc) + 32'd4 && fd_valid));

    assert_target_R4: assert property (@(posedge clk) disable iff (rst)
        (!stall && br_taken) |=> (fetch_pc == $past(fd_pc) + 32'd4
            + {{14{$past(dec_offset[15])}}, $past(dec_offset), 2'b00}));

    assert_squash_bubble_R5: assert property (@(posedge clk) disable iff (rst)
        squash |=> !fd_valid);

    assert_delay_slot_R7: assert property (@(posedge clk) disable iff (rst)
        (delay_mode && br_taken && !stall) |-> !squash);

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
        stall |=> ($stable(fetch_pc) && $stable(fd_valid) && $stable(fd_pc) && $stable(fd_instr)));

    assert_stall_nosquash_R8: assert property (@(posedge clk) disable iff (rst)
        stall |-> !squash);

    assert_bubble_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        !fd_valid |-> (!br_taken && !squash));
endmodule

bind early_branch_fetch early_branch_fetch_chk #(.RESET_VEC(RESET_VEC)) i_chk (
    .clk       (clk),
    .rst       (rst),
    .stall     (stall),
    .delay_mode(delay_mode),
    .br_taken  (br_taken),
    .dec_offset(dec_offset),
    .fetch_pc  (fetch_pc),
    .squash    (squash),
    .fd_valid  (fd_valid),
    .fd_pc     (fd_pc),
    .fd_instr  (fd_instr)
);

// File: tb/test_early_branch_fetch.sv
module test_early_branch_fetch;
    localparam logic [31:0] VEC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        stall = 1'b0;
    logic        delay_mode = 1'b0;
    logic [31:0] fetch_instr = '0;
    logic [1:0]  dec_br = 2'd0;
    logic [31:0] dec_rs_val = '0;
    logic [15:0] dec_offset = '0;
    logic [31:0] fetch_pc;
    logic        squash;
    logic        fd_valid;
    logic [31:0] fd_pc;
    logic [31:0] fd_instr;

    int checks = 0;
    int fails  = 0;

    // behavioural reference state
    logic [31:0] m_pc;
    logic        m_fv;
    logic [31:0] m_fpc;
    logic [31:0] m_fi;

    always #2.5 clk = ~clk;

    early_branch_fetch #(.RESET_VEC(VEC)) i_early_branch_fetch (
        .clk(clk), .rst(rst), .stall(stall), .delay_mode(delay_mode),
        .fetch_instr(fetch_instr), .dec_br(dec_br), .dec_rs_val(dec_rs_val),
        .dec_offset(dec_offset), .fetch_pc(fetch_pc), .squash(squash),
        .fd_valid(fd_valid), .fd_pc(fd_pc), .fd_instr(fd_instr)
    );

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // one cycle: drive at negedge, compare outputs, advance model at posedge
    task automatic step(input string req, input logic st, input logic dm,
                        input logic [1:0] br, input logic [31:0] rs, input logic [15:0] off);
        logic cond;
        logic tk;
        logic [31:0] tgt;
        stall = st; delay_mode = dm; dec_br = br; dec_rs_val = rs; dec_offset = off;
        fetch_instr = m_pc ^ 32'hC0DE_0000;
        #1;
        cond = (br == 2'd1) ? (rs == 0) : (br == 2'd2) ? (rs != 0) : 1'b0;
        tk   = m_fv && cond && !st;
        tgt  = m_fpc + 32'd4 + ({{16{off[15]}}, off} << 2);
        chk(req, "fetch_pc", fetch_pc, m_pc);
        chk(req, "fd_valid", {31'd0, fd_valid}, {31'd0, m_fv});
        chk(req, "fd_pc", fd_pc, m_fpc);
        chk(req, "squash", {31'd0, squash}, {31'd0, tk && !dm});
        @(posedge clk);
        if (!st) begin
            m_fv  = !(tk && !dm);
            m_fpc = m_pc;
            m_fi  = fetch_instr;
            m_pc  = tk ? tgt : m_pc + 32'd4;
        end
        @(negedge clk);
        chk(req, "fd_instr", fd_instr, m_fi);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        @(posedge clk); @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        m_pc = VEC; m_fv = 1'b0; m_fpc = '0; m_fi = '0;
        chk("R1", "fetch_pc", fetch_pc, VEC);
        chk("R1", "fd_valid", {31'd0, fd_valid}, 32'd0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        do_reset();
        // R9: branch code on reset bubble ignored
        step("R9", 0, 0, 2'd1, 32'd0, 16'd8);
        step("R2", 0, 0, 2'd0, 32'd7, 16'd8);
        step("R2", 0, 0, 2'd3, 32'd0, 16'd8);     // R3 code 3 never taken
        // R5 / R4: taken EQZ in squash mode
        step("R5", 0, 0, 2'd1, 32'd0, 16'd16);
        step("R9", 0, 0, 2'd2, 32'd9, 16'd3);     // bubble after squash
        step("R2", 0, 0, 2'd0, 32'd0, 16'd0);
        // R3 / R6: not-taken cases
        step("R6", 0, 0, 2'd1, 32'd3, 16'd40);
        step("R6", 0, 0, 2'd2, 32'd0, 16'd40);
        // R4: NEZ taken backward
        step("R4", 0, 0, 2'd2, 32'h8000_0000, 16'hFFF0);
        step("R2", 0, 0, 2'd0, 32'd0, 16'd0);
        step("R2", 0, 0, 2'd0, 32'd0, 16'd0);
        // R8: stall with a taken branch pending
        step("R8", 1, 0, 2'd1, 32'd0, 16'd100);
        step("R8", 1, 1, 2'd2, 32'd1, 16'd100);
        step("R8", 0, 0, 2'd0, 32'd0, 16'd0);
        // R7: delayed mode
        step("R7", 0, 1, 2'd1, 32'd0, 16'd32);
        step("R7", 0, 1, 2'd0, 32'd0, 16'd0);     // delay slot live in decode
        step("R7", 0, 1, 2'd2, 32'd5, 16'hFFFE);
        step("R7", 0, 1, 2'd0, 32'd0, 16'd0);
        step("R2", 0, 1, 2'd0, 32'd0, 16'd0);
        // mid-run reset
        do_reset();
        step("R2", 0, 0, 2'd0, 32'd0, 16'd0);
        step("R2", 0, 0, 2'd0, 32'd0, 16'd0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule